// File: doc/BRIEF.md
# Shadowed PWM Compare Event Generator

This block runs a time-base counter and turns two compare values into single-cycle event strobes. Those strobes feed a separate waveform-action stage. The counter has three modes: count up, count down and count up-down. Its turning point is a programmable period. Each cycle that the time-base enable is high, the block raises strobes for counter-at-zero and counter-at-period. For each of the two compare channels, A and B, it also raises a compare-up strobe and a compare-down strobe.

Software writes a compare value into a shadow register. The shadow is copied into the active register once per period, either when the counter is at zero or when it is at the period. A select bit picks which. A bypass input makes writes land in the active register at once.

A compare value that equals or exceeds the period gets defined treatment. In some cases its event is suppressed. In others the event moves onto the period match. This lets full-scale duty values behave predictably.

Top module: `pwm_cmp_evgen`

## Requirements
- R1: After reset the counter is 0, the direction output is 1 in up mode, and both shadow and active compare registers hold 0. A compare value of 0 is therefore live straight out of reset.
- R2: Mode encoding is 00 = up. In up mode the counter steps 0,1,…,period and then returns to 0. Any value at or above the period wraps to 0.
- R3: Mode 01 = down. In down mode the counter steps downward and reloads the period after 0. Out of reset (counter 0), the first enabled cycle loads the period. The direction output is 0.
- R4: Modes 10 and 11 = up-down. The counter climbs to the period, descends to 0 and climbs again. The direction output gives the direction of the next step: 1 while the counter is 0 and 0 while it is at the period.
- R5: evZero pulses on each enabled cycle in which the counter is 0. evPrd pulses on each enabled cycle in which the counter equals the period.
- R6: In up mode, compare-up fires when the counter equals the active compare value, provided that value is not above the period. A value above the period never fires. Compare-down never fires in up mode.
- R7: In down mode, compare-up never fires. Compare-down fires on an equality match when the value is below the period. When the value is at or above the period, compare-down fires on the period match instead.
- R8: In up-down mode with a value below the period, compare-up fires on a match while the direction output is 1 and compare-down fires on a match while it is 0. With a value at or above the period, both strobes fire on the period match.
- R9: A write lands in the shadow register. The shadow is copied to the active register on the enabled cycle at the load point, and the new value governs events from the following cycle. The load point is counter 0 when loadSel = 0 and counter = period when loadSel = 1.
- R10: With shadowOff = 1, a write updates the active register on the next clock edge, in the middle of a period.
- R11: While tbEn is 0, the counter and direction hold and no event strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tbEn | input | 1 | Time-base enable from the prescaler |
| cntMode | input | 2 | 00 up, 01 down, 10/11 up-down |
| prdVal | input | CNT_W | Period |
| loadSel | input | 1 | Shadow load point: 0 at zero, 1 at period |
| shadowOff | input | 1 | Bypass the shadow registers |
| cmpAWr | input | 1 | Write strobe for compare A |
| cmpAData | input | CNT_W | Compare A write data |
| cmpBWr | input | 1 | Write strobe for compare B |
| cmpBData | input | CNT_W | Compare B write data |
| cntVal | output | CNT_W | Counter value |
| cntDir | output | 1 | Next-step direction (1 = up) |
| evZero | output | 1 | Counter-at-zero strobe |
| evPrd | output | 1 | Counter-at-period strobe |
| evCauA | output | 1 | Compare A up strobe |
| evCadA | output | 1 | Compare A down strobe |
| evCauB | output | 1 | Compare B up strobe |
| evCadB | output | 1 | Compare B down strobe |

## Verification
Each vector puts one compare inside the period and the other on the period, above it, or at zero. It then counts all six strobes over whole periods in each mode. These counts separate a plain equality match from suppression (up mode) and from relocation to the period match (down and up-down modes). The zero compare in up-down mode shows which direction the bottom turning point counts as. Directed runs then write a new compare in mid-period. These runs show whether the new value takes hold at zero, at the period or at once, because a zero target is caught or missed depending on the load point.

// File: rtl/pwm_evgen_pkg.sv
package pwm_evgen_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_UPD2 = 2'b11
  } cnt_mode_e;

  // strobes from the time-base control to the compare datapath
  typedef struct packed {
    logic      tick;
    logic      atZero;
    logic      atPrd;
    logic      dirUp;
    logic      loadNow;
    cnt_mode_e mode;
  } tb_strb_t;

  typedef struct packed {
    logic up;
    logic down;
  } cmp_evt_t;

endpackage

// File: rtl/pwm_evgen_tbctl.sv
module pwm_evgen_tbctl
  import pwm_evgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tbEn,
  input  logic [1:0]       cntMode,
  input  logic [CNT_W-1:0] prdVal,
  input  logic             loadSel,
  output logic [CNT_W-1:0] cnt,
  output tb_strb_t         strb
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  cnt_mode_e        mode;
  logic             dirReg;
  logic             nxtDir;
  logic [CNT_W-1:0] nxtCnt;
  logic             curDir;

  assign mode = cnt_mode_e'(cntMode);

  always_comb begin
    nxtCnt = cnt;
    nxtDir = dirReg;
    unique case (mode)
      MODE_UP: begin
        nxtCnt = (cnt >= prdVal) ? ZERO : cnt + ONE;
        nxtDir = 1'b1;
      end
      MODE_DOWN: begin
        nxtCnt = (cnt == ZERO) ? prdVal : cnt - ONE;
        nxtDir = 1'b0;
      end
      default: begin
        if (curDir) begin
          if (cnt >= prdVal) nxtCnt = (cnt == ZERO) ? ZERO : cnt - ONE;
          else               nxtCnt = cnt + ONE;
        end else begin
          if (cnt == ZERO)   nxtCnt = (prdVal == ZERO) ? ZERO : ONE;
          else               nxtCnt = cnt - ONE;
        end
        if (nxtCnt == ZERO)        nxtDir = 1'b1;
        else if (nxtCnt >= prdVal) nxtDir = 1'b0;
        else if (cnt >= prdVal)    nxtDir = 1'b0;
        else                       nxtDir = curDir;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= ZERO;
      dirReg <= 1'b1;
    end else if (tbEn) begin
      cnt    <= nxtCnt;
      dirReg <= nxtDir;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_UP:   curDir = 1'b1;
      MODE_DOWN: curDir = 1'b0;
      default:   curDir = dirReg;
    endcase
  end

  always_comb begin
    strb.tick    = tbEn;
    strb.atZero  = tbEn && (cnt == ZERO);
    strb.atPrd   = tbEn && (cnt == prdVal);
    strb.dirUp   = curDir;
    strb.loadNow = loadSel ? strb.atPrd : strb.atZero;
    strb.mode    = mode;
  end

endmodule

// File: rtl/pwm_evgen_cmpch.sv
module pwm_evgen_cmpch
  import pwm_evgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tb_strb_t         strb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prdVal,
  input  logic             bypass,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output cmp_evt_t         evt
);

  logic [CNT_W-1:0] shadowReg;
  logic [CNT_W-1:0] activeReg;
  logic             atOrAbove;
  logic             above;
  logic             hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowReg <= '0;
      activeReg <= '0;
    end else begin
      if (wrEn) shadowReg <= wrData;
      if (wrEn && bypass)  activeReg <= wrData;
      else if (strb.loadNow) activeReg <= shadowReg;
    end
  end

  assign atOrAbove = (activeReg >= prdVal);
  assign above     = (activeReg > prdVal);
  assign hit       = (cnt == activeReg);

  always_comb begin
    evt = '0;
    if (strb.tick) begin
      unique case (strb.mode)
        MODE_UP: begin
          evt.up = hit && !above;
        end
        MODE_DOWN: begin
          evt.down = atOrAbove ? strb.atPrd : hit;
        end
        default: begin
          if (atOrAbove) begin
            evt.up   = strb.atPrd;
            evt.down = strb.atPrd;
          end else begin
            evt.up   = hit && strb.dirUp;
            evt.down = hit && !strb.dirUp;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pwm_evgen_cmpdp.sv
module pwm_evgen_cmpdp
  import pwm_evgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CMP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tb_strb_t         strb,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prdVal,
  input  logic             bypass,
  input  logic [N_CMP-1:0] wrEn,
  input  logic [CNT_W-1:0] wrData [N_CMP],
  output cmp_evt_t         evt [N_CMP]
);

  for (genvar ch = 0; ch < N_CMP; ch++) begin : g_ch
    pwm_evgen_cmpch #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rstN   (rstN),
      .strb   (strb),
      .cnt    (cnt),
      .prdVal (prdVal),
      .bypass (bypass),
      .wrEn   (wrEn[ch]),
      .wrData (wrData[ch]),
      .evt    (evt[ch])
    );
  end

endmodule

// File: rtl/pwm_cmp_evgen.sv
module pwm_cmp_evgen
  import pwm_evgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tbEn,
  input  logic [1:0]       cntMode,
  input  logic [CNT_W-1:0] prdVal,
  input  logic             loadSel,
  input  logic             shadowOff,
  input  logic             cmpAWr,
  input  logic [CNT_W-1:0] cmpAData,
  input  logic             cmpBWr,
  input  logic [CNT_W-1:0] cmpBData,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntDir,
  output logic             evZero,
  output logic             evPrd,
  output logic             evCauA,
  output logic             evCadA,
  output logic             evCauB,
  output logic             evCadB
);

  localparam int N_CMP = 2;

  tb_strb_t         strb;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wrData [N_CMP];
  cmp_evt_t         evt [N_CMP];

  pwm_evgen_tbctl #(.CNT_W(CNT_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .tbEn    (tbEn),
    .cntMode (cntMode),
    .prdVal  (prdVal),
    .loadSel (loadSel),
    .cnt     (cnt),
    .strb    (strb)
  );

  assign wrData[0] = cmpAData;
  assign wrData[1] = cmpBData;

  pwm_evgen_cmpdp #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cnt    (cnt),
    .prdVal (prdVal),
    .bypass (shadowOff),
    .wrEn   ({cmpBWr, cmpAWr}),
    .wrData (wrData),
    .evt    (evt)
  );

  assign cntVal = cnt;
  assign cntDir = strb.dirUp;
  assign evZero = strb.atZero;
  assign evPrd  = strb.atPrd;
  assign evCauA = evt[0].up;
  assign evCadA = evt[0].down;
  assign evCauB = evt[1].up;
  assign evCadB = evt[1].down;

endmodule

// File: rtl/pwm_evgen_chk.sv
module pwm_evgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tbEn,
  input logic [1:0]       cntMode,
  input logic [CNT_W-1:0] prdVal,
  input logic [CNT_W-1:0] cntVal,
  input logic             cntDir,
  input logic             evZero,
  input logic             evPrd,
  input logic             evCauA,
  input logic             evCadA,
  input logic             evCauB,
  input logic             evCadB
);

  AST_UP_NO_CAD: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'b00) |-> (!evCadA && !evCadB)); // R6

  AST_DN_NO_CAU: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'b01) |-> (!evCauA && !evCauB)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !tbEn |-> !(evZero || evPrd || evCauA || evCadA || evCauB || evCadB)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tbEn |=> $stable(cntVal)); // R11

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tbEn && cntMode == 2'b00 && cntVal >= prdVal) |=> (cntVal == '0)); // R2

  AST_DN_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tbEn && cntMode == 2'b01 && cntVal == '0) |=> (cntVal == $past(prdVal))); // R3

  AST_UPDN_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tbEn && cntMode[1] && cntVal == '0 && prdVal != '0) |=> (cntVal == CNT_W'(1))); // R4

  AST_UPDN_BOTH_AT_PRD: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode[1] && evCauA && evCadA) |-> (cntVal == prdVal)); // R8

endmodule

bind pwm_cmp_evgen pwm_evgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tbEn    (tbEn),
  .cntMode (cntMode),
  .prdVal  (prdVal),
  .cntVal  (cntVal),
  .cntDir  (cntDir),
  .evZero  (evZero),
  .evPrd   (evPrd),
  .evCauA  (evCauA),
  .evCadA  (evCadA),
  .evCauB  (evCauB),
  .evCadB  (evCadB)
);

// File: tb/sim_pwm_cmp_evgen.sv
module sim_pwm_cmp_evgen;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] prd;
    logic [7:0] cA;
    logic [7:0] cB;
    logic [7:0] n;
    logic [7:0] eZ;
    logic [7:0] eP;
    logic [7:0] aU;
    logic [7:0] aD;
    logic [7:0] bU;
    logic [7:0] bD;
  } vec_t;

  localparam int NVEC = 8;
  // mode, prd, cmpA, cmpB, samples, zero, period, A-up, A-down, B-up, B-down
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 8'd4, 8'd2, 8'd4, 8'd10, 8'd2, 8'd2, 8'd2, 8'd0, 8'd2, 8'd0}, // R6 in range / on period
    '{2'd0, 8'd4, 8'd5, 8'd0, 8'd10, 8'd2, 8'd2, 8'd0, 8'd0, 8'd2, 8'd0}, // R6 above period
    '{2'd1, 8'd4, 8'd2, 8'd4, 8'd10, 8'd2, 8'd2, 8'd0, 8'd2, 8'd0, 8'd2}, // R7
    '{2'd1, 8'd4, 8'd7, 8'd0, 8'd10, 8'd2, 8'd2, 8'd0, 8'd2, 8'd0, 8'd2}, // R7 above / zero
    '{2'd2, 8'd4, 8'd2, 8'd4, 8'd16, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2}, // R8
    '{2'd2, 8'd4, 8'd1, 8'd9, 8'd16, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2}, // R8 above
    '{2'd2, 8'd4, 8'd0, 8'd3, 8'd16, 8'd2, 8'd2, 8'd2, 8'd0, 8'd2, 8'd2}, // R8 zero
    '{2'd3, 8'd4, 8'd2, 8'd4, 8'd16, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2}  // R8 mode 11
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             tbEn;
  logic [1:0]       cntMode;
  logic [CNT_W-1:0] prdVal;
  logic             loadSel;
  logic             shadowOff;
  logic             cmpAWr;
  logic [CNT_W-1:0] cmpAData;
  logic             cmpBWr;
  logic [CNT_W-1:0] cmpBData;
  logic [CNT_W-1:0] cntVal;
  logic             cntDir;
  logic             evZero, evPrd, evCauA, evCadA, evCauB, evCadB;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_evgen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .tbEn(tbEn), .cntMode(cntMode), .prdVal(prdVal),
    .loadSel(loadSel), .shadowOff(shadowOff),
    .cmpAWr(cmpAWr), .cmpAData(cmpAData), .cmpBWr(cmpBWr), .cmpBData(cmpBData),
    .cntVal(cntVal), .cntDir(cntDir), .evZero(evZero), .evPrd(evPrd),
    .evCauA(evCauA), .evCadA(evCadA), .evCauB(evCauB), .evCadB(evCadB)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic waitCnt(input int v);
    for (int g = 0; g < 64 && cntVal != CNT_W'(v); g++) step();
  endtask

  // reset, configure, preload both compares through the bypass path
  task automatic setup(input logic [1:0] m, input int prd, input int a, input int b,
                       input logic ls, input logic byp);
    rstN = 1'b0; tbEn = 1'b0; cntMode = m; prdVal = CNT_W'(prd);
    loadSel = ls; shadowOff = 1'b1; cmpAWr = 1'b0; cmpBWr = 1'b0;
    cmpAData = '0; cmpBData = '0;
    step(); step();
    rstN = 1'b1;
    step();
    cmpAWr = 1'b1; cmpAData = CNT_W'(a);
    cmpBWr = 1'b1; cmpBData = CNT_W'(b);
    step();
    cmpAWr = 1'b0; cmpBWr = 1'b0; shadowOff = byp;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; tbEn = 1'b0; cntMode = 2'b00; prdVal = CNT_W'(4);
    loadSel = 1'b0; shadowOff = 1'b0; cmpAWr = 1'b0; cmpBWr = 1'b0;
    cmpAData = '0; cmpBData = '0;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      int cZ, cP, cAU, cAD, cBU, cBD;
      setup(VEC[i].mode, int'(VEC[i].prd), int'(VEC[i].cA), int'(VEC[i].cB), 1'b0, 1'b0);
      cZ = 0; cP = 0; cAU = 0; cAD = 0; cBU = 0; cBD = 0;
      tbEn = 1'b1;
      #1;
      for (int k = 0; k < int'(VEC[i].n); k++) begin
        cZ += int'(evZero); cP += int'(evPrd);
        cAU += int'(evCauA); cAD += int'(evCadA);
        cBU += int'(evCauB); cBD += int'(evCadB);
        step();
      end
      tbEn = 1'b0;
      chk($sformatf("R5 zero count vec%0d", i), cZ, int'(VEC[i].eZ));
      chk($sformatf("R5 period count vec%0d", i), cP, int'(VEC[i].eP));
      chk($sformatf("R6/R7/R8 A-up count vec%0d", i), cAU, int'(VEC[i].aU));
      chk($sformatf("R6/R7/R8 A-down count vec%0d", i), cAD, int'(VEC[i].aD));
      chk($sformatf("R6/R7/R8 B-up count vec%0d", i), cBU, int'(VEC[i].bU));
      chk($sformatf("R6/R7/R8 B-down count vec%0d", i), cBD, int'(VEC[i].bD));
    end

    // R1: reset state, compare 0 is live
    rstN = 1'b0; tbEn = 1'b0; cntMode = 2'b00; prdVal = CNT_W'(4); shadowOff = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
    chk("R1 counter after reset", int'(cntVal), 0);
    chk("R1 direction after reset", int'(cntDir), 1);
    chk("R11 no zero strobe while idle", int'(evZero), 0);
    tbEn = 1'b1; #1;
    chk("R1 active compare A is zero", int'(evCauA), 1);
    chk("R1 active compare B is zero", int'(evCauB), 1);
    tbEn = 1'b0;

    // R11: hold while disabled
    setup(2'b00, 4, 2, 9, 1'b0, 1'b0);
    tbEn = 1'b1; #1;
    waitCnt(2);
    tbEn = 1'b0;
    step(); step(); step();
    chk("R11 counter holds", int'(cntVal), 2);
    chk("R11 compare strobe gated", int'(evCauA), 0);
    tbEn = 1'b1; #1;
    chk("R11 compare strobe returns", int'(evCauA), 1);
    step();
    chk("R2 up step", int'(cntVal), 3);
    step(); step();
    chk("R2 wrap to zero", int'(cntVal), 0);
    tbEn = 1'b0;

    // R3: down mode reload from reset
    setup(2'b01, 4, 9, 9, 1'b0, 1'b0);
    chk("R3 direction in down mode", int'(cntDir), 0);
    tbEn = 1'b1; #1;
    step();
    chk("R3 reload period", int'(cntVal), 4);
    step();
    chk("R3 count down", int'(cntVal), 3);
    tbEn = 1'b0;

    // R4: up-down turning points
    setup(2'b10, 3, 9, 9, 1'b0, 1'b0);
    tbEn = 1'b1; #1;
    waitCnt(3);
    chk("R4 direction at period", int'(cntDir), 0);
    step();
    chk("R4 descend after period", int'(cntVal), 2);
    waitCnt(0);
    chk("R4 direction at zero", int'(cntDir), 1);
    step();
    chk("R4 climb after zero", int'(cntVal), 1);
    tbEn = 1'b0;

    // R9: load at zero
    setup(2'b00, 4, 2, 9, 1'b0, 1'b0);
    tbEn = 1'b1; #1;
    waitCnt(1);
    cmpAWr = 1'b1; cmpAData = CNT_W'(3);
    step();
    cmpAWr = 1'b0; #1;
    chk("R9 old value still active at 2", int'(evCauA), 1);
    step();
    chk("R9 new value not yet active at 3", int'(evCauA), 0);
    waitCnt(0);
    step(); step();
    chk("R9 old value gone after zero load", int'(evCauA), 0);
    step();
    chk("R9 new value active after zero load", int'(evCauA), 1);
    tbEn = 1'b0;

    // R9: load at period catches a zero target in the same turn
    setup(2'b00, 4, 2, 9, 1'b1, 1'b0);
    tbEn = 1'b1; #1;
    waitCnt(3);
    cmpAWr = 1'b1; cmpAData = CNT_W'(0);
    step();
    cmpAWr = 1'b0; #1;
    chk("R9 counter at period", int'(cntVal), 4);
    step();
    chk("R9 period load hits zero target", int'(evCauA), 1);
    tbEn = 1'b0;

    // R10: bypass takes effect mid-period
    setup(2'b00, 4, 2, 9, 1'b0, 1'b1);
    tbEn = 1'b1; #1;
    waitCnt(1);
    cmpAWr = 1'b1; cmpAData = CNT_W'(3);
    step();
    cmpAWr = 1'b0; #1;
    chk("R10 old value dropped at once", int'(evCauA), 0);
    step();
    chk("R10 new value same period", int'(evCauA), 1);
    tbEn = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule